// File: doc/BRIEF.md
# ECC Scrub Refresh Engine

This engine scrubs one 8-byte location of a banked SRAM whose 32-bit words each carry seven SECDED check bits. Software starts a scrub by writing a byte address into the engine's refresh address register. The engine reads the two 32-bit words at that location and repairs any single-bit error in either one. It then writes each repairable word back with freshly generated check bits.

While a scrub runs, the engine raises a busy flag. It also drives a per-bank lock line that the surrounding arbiter uses to hold every other requester off the bank being scrubbed. Two sticky flags record that a corrected error or an uncorrectable error was seen. Software clears each flag by writing 1 to it. To sweep the whole memory, software steps the address by 8 after each scrub. When ECC is disabled for a bank, a scrub aimed at that bank does nothing.

Top module: `scrub_engine`

## Requirements
- R1: After reset, busy_o, both sticky flags, bank_lock_o, mem_req_o and rfa_o are all zero.
- R2: A write on rfa_we_i while idle stores rfa_wdata_i with bits 2:0 forced to zero into rfa_o, and targets the word addresses {rfa_o[AW-1:3],0} and {rfa_o[AW-1:3],1}.
- R3: A scrub makes exactly four SRAM cycles, one access per cycle: read word 0, read word 1, write word 0, write word 1. Read data returns on mem_rdata_i one cycle after the request.
- R4: The stored 39-bit word holds data in bits 31:0, check bits c0..c5 in bits 37:32 and the overall parity of bits 37:0 in bit 38. Data bit i occupies the (i+1)-th Hamming position, counting upward, that is not a power of two (3,5,6,7,9,...). Check bit ck is the XOR of the data bits whose position has bit k set. A word with no error or with a single-bit error in any of its 39 bits is written back as the clean encoding of its corrected data, and a single-bit error sets sbe_flag_o.
- R5: A word with a double-bit error is not written back (no request in its write cycle), and it sets mbe_flag_o. The other word of the pair is still handled normally.
- R6: busy_o rises in the cycle after the accepting write and stays high for exactly four cycles. Hardware then clears it.
- R7: While busy_o is high, bank_lock_o has exactly one bit set, at the index rfa_o[AW-1:BANK_AW]. At all other times it is zero.
- R8: Writes to the refresh address register while busy are ignored. They change neither rfa_o nor the running scrub, and they start no further scrub.
- R9: When ecc_dis_i is set for the addressed bank, an accepted write updates rfa_o, but busy_o stays low, no SRAM access is made and no lock is raised.
- R10: Both flags are sticky. flag_clr_i[0] clears sbe_flag_o and flag_clr_i[1] clears mbe_flag_o, and each leaves the other flag alone.
- R11: Back-to-back scrubs stepping the address by 8 across a bank boundary each touch their own pair of words, and the lock follows the bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rfa_we_i | input | 1 | Write strobe for the refresh address register |
| rfa_wdata_i | input | AW | Byte address written to start a scrub |
| ecc_dis_i | input | NB | Per-bank ECC disable |
| flag_clr_i | input | 2 | Write-1-to-clear: bit 0 clears the corrected flag, bit 1 clears the uncorrectable flag |
| rfa_o | output | AW | Current refresh address register |
| busy_o | output | 1 | Scrub in progress |
| sbe_flag_o | output | 1 | Sticky flag: a single-bit error was corrected |
| mbe_flag_o | output | 1 | Sticky flag: an uncorrectable error was found |
| bank_lock_o | output | NB | Lockout line for each bank |
| mem_req_o | output | 1 | SRAM access request |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | AW-2 | SRAM word address |
| mem_wdata_o | output | 39 | SRAM write codeword |
| mem_rdata_i | input | 39 | SRAM read codeword, one cycle after the request |

## Verification
The bench places faults in every class of codeword bit: data bits, check bits and the overall parity bit. A decoder that maps syndromes to the wrong positions, or that treats a parity-bit fault as a double error, writes back wrong data. The bench also places double-bit faults in each word of a pair. A design that writes such a word back anyway, or that drops the good neighbour word, is caught by the write scoreboard. Two further cases are a register write arriving in the middle of a scrub and a scrub aimed at a disabled bank. Either one would show up as a moved address, an extra SRAM access or a stray busy cycle. A final sweep across a bank boundary catches a lock decoded from the wrong address bits.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  localparam int DW = 32;
  localparam int HW = 6;
  localparam int EW = DW + HW + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_RD0, ST_RD1, ST_WR0, ST_WR1} scrub_st_e;

  function automatic logic is_pow2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  // Hamming check bits; data placed at non-power-of-two positions 3..38
  function automatic logic [HW-1:0] ham_chk(input logic [DW-1:0] d);
    logic [HW-1:0] c;
    int idx;
    c = '0;
    idx = 0;
    for (int pos = 3; pos < EW; pos++) begin
      if (!is_pow2(pos)) begin
        for (int k = 0; k < HW; k++) begin
          if (pos[k]) c[k] = c[k] ^ d[idx];
        end
        idx++;
      end
    end
    return c;
  endfunction

  function automatic logic [DW-1:0] flip_at(input logic [DW-1:0] d, input logic [HW-1:0] syn);
    logic [DW-1:0] r;
    int idx;
    r = d;
    idx = 0;
    for (int pos = 3; pos < EW; pos++) begin
      if (!is_pow2(pos)) begin
        if (syn == HW'(pos)) r[idx] = ~r[idx];
        idx++;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/scrub_ecc_enc.sv
module scrub_ecc_enc
  import scrub_pkg::*;
(
  input  logic [DW-1:0] data_i,
  output logic [EW-1:0] cw_o
);
  logic [HW-1:0] chk;

  always_comb begin
    chk  = ham_chk(data_i);
    cw_o = {^{chk, data_i}, chk, data_i};
  end
endmodule

// File: rtl/scrub_ecc_dec.sv
module scrub_ecc_dec
  import scrub_pkg::*;
(
  input  logic [EW-1:0] cw_i,
  output logic [DW-1:0] data_o,
  output logic          sbe_o,
  output logic          mbe_o
);
  logic [HW-1:0] syn;
  logic          odd;

  always_comb begin
    syn    = ham_chk(cw_i[DW-1:0]) ^ cw_i[DW+HW-1:DW];
    odd    = ^cw_i;
    data_o = cw_i[DW-1:0];
    sbe_o  = 1'b0;
    mbe_o  = 1'b0;
    if (odd) begin
      // odd weight: single flip, unless syndrome points past the codeword
      if (syn > HW'(EW - 1)) begin
        mbe_o = 1'b1;
      end else begin
        sbe_o  = 1'b1;
        data_o = flip_at(cw_i[DW-1:0], syn);
      end
    end else if (syn != '0) begin
      mbe_o = 1'b1;
    end
  end
endmodule

// File: rtl/scrub_ctrl.sv
module scrub_ctrl
  import scrub_pkg::*;
#(
  parameter int NB      = 8,
  parameter int BANK_AW = 8,
  parameter int AW      = BANK_AW + $clog2(NB)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rfa_we_i,
  input  logic [AW-1:0]         rfa_wdata_i,
  input  logic [NB-1:0]         ecc_dis_i,
  output scrub_st_e             st_o,
  output logic [AW-1:0]         rfa_o,
  output logic [$clog2(NB)-1:0] bank_o
);
  localparam int BW = $clog2(NB);

  scrub_st_e     st_q, st_d;
  logic [AW-1:0] rfa_q;
  logic [BW-1:0] wr_bank;
  logic          accept;

  assign wr_bank = rfa_wdata_i[AW-1:BANK_AW];
  assign accept  = rfa_we_i && (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rfa_q <= '0;
    else if (accept) rfa_q <= rfa_wdata_i & ~AW'(7);
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept && !ecc_dis_i[wr_bank]) st_d = ST_RD0;
      ST_RD0:  st_d = ST_RD1;
      ST_RD1:  st_d = ST_WR0;
      ST_WR0:  st_d = ST_WR1;
      ST_WR1:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign st_o   = st_q;
  assign rfa_o  = rfa_q;
  assign bank_o = rfa_q[AW-1:BANK_AW];

  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfa_q[2:0] == 3'b000); // R2
  AST_BUSY_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR1) |=> (st_q == ST_IDLE)); // R6
  AST_RFA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> $stable(rfa_q)); // R8
  AST_DIS_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfa_we_i && st_q == ST_IDLE && ecc_dis_i[wr_bank]) |=> (st_q == ST_IDLE)); // R9
endmodule

// File: rtl/scrub_engine.sv
module scrub_engine
  import scrub_pkg::*;
#(
  parameter  int NB      = 8,
  parameter  int BANK_AW = 8,
  localparam int AW      = BANK_AW + $clog2(NB),
  localparam int WAW     = AW - 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rfa_we_i,
  input  logic [AW-1:0]  rfa_wdata_i,
  input  logic [NB-1:0]  ecc_dis_i,
  input  logic [1:0]     flag_clr_i,
  output logic [AW-1:0]  rfa_o,
  output logic           busy_o,
  output logic           sbe_flag_o,
  output logic           mbe_flag_o,
  output logic [NB-1:0]  bank_lock_o,
  output logic           mem_req_o,
  output logic           mem_we_o,
  output logic [WAW-1:0] mem_addr_o,
  output logic [EW-1:0]  mem_wdata_o,
  input  logic [EW-1:0]  mem_rdata_i
);
  localparam int BW = $clog2(NB);

  scrub_st_e     st;
  logic [BW-1:0] bank;
  logic [DW-1:0] dec_data, w0_q, w1_q, wr_data;
  logic          dec_sbe, dec_mbe, w0_bad_q, w1_bad_q;
  logic          rd_phase, sbe_set, mbe_set;

  scrub_ctrl #(.NB(NB), .BANK_AW(BANK_AW), .AW(AW)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rfa_we_i    (rfa_we_i),
    .rfa_wdata_i (rfa_wdata_i),
    .ecc_dis_i   (ecc_dis_i),
    .st_o        (st),
    .rfa_o       (rfa_o),
    .bank_o      (bank)
  );

  scrub_ecc_dec i_dec (
    .cw_i   (mem_rdata_i),
    .data_o (dec_data),
    .sbe_o  (dec_sbe),
    .mbe_o  (dec_mbe)
  );

  // rdata of word 0 is valid in RD1, of word 1 in WR0
  assign rd_phase = (st == ST_RD1) || (st == ST_WR0);
  assign sbe_set  = rd_phase && dec_sbe;
  assign mbe_set  = rd_phase && dec_mbe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w0_q     <= '0;
      w1_q     <= '0;
      w0_bad_q <= 1'b0;
      w1_bad_q <= 1'b0;
    end else if (st == ST_RD1) begin
      w0_q     <= dec_data;
      w0_bad_q <= dec_mbe;
    end else if (st == ST_WR0) begin
      w1_q     <= dec_data;
      w1_bad_q <= dec_mbe;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sbe_flag_o <= 1'b0;
      mbe_flag_o <= 1'b0;
    end else begin
      if (sbe_set)            sbe_flag_o <= 1'b1;
      else if (flag_clr_i[0]) sbe_flag_o <= 1'b0;
      if (mbe_set)            mbe_flag_o <= 1'b1;
      else if (flag_clr_i[1]) mbe_flag_o <= 1'b0;
    end
  end

  assign wr_data = (st == ST_WR0) ? w0_q : w1_q;

  scrub_ecc_enc i_enc (
    .data_i (wr_data),
    .cw_o   (mem_wdata_o)
  );

  assign busy_o     = (st != ST_IDLE);
  assign mem_we_o   = (st == ST_WR0) || (st == ST_WR1);
  assign mem_req_o  = (st == ST_RD0) || (st == ST_RD1) ||
                      ((st == ST_WR0) && !w0_bad_q) || ((st == ST_WR1) && !w1_bad_q);
  assign mem_addr_o = {rfa_o[AW-1:3], (st == ST_RD1) || (st == ST_WR1)};

  for (genvar b = 0; b < NB; b++) begin : g_lock
    assign bank_lock_o[b] = busy_o && (bank == BW'(b));
  end

  AST_LOCK_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_lock_o)); // R7
  AST_LOCK_WHEN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ($countones(bank_lock_o) == 1)); // R7
  AST_READ_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && !mem_addr_o[0]) |=>
      (mem_req_o && !mem_we_o && mem_addr_o == $past(mem_addr_o) + WAW'(1))); // R3
  AST_SBE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sbe_flag_o && !flag_clr_i[0]) |=> sbe_flag_o); // R10
  AST_MBE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mbe_flag_o && !flag_clr_i[1]) |=> mbe_flag_o); // R10
endmodule

// File: tb/test_scrub_engine.sv
`timescale 1ns/1ps
module test_scrub_engine;
  localparam int NB = 8, BANK_AW = 8, AW = 11, WAW = 9, EW = 39;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           rfa_we = 1'b0;
  logic [AW-1:0]  rfa_wdata = '0;
  logic [NB-1:0]  ecc_dis = '0;
  logic [1:0]     flag_clr = '0;
  logic [AW-1:0]  rfa;
  logic           busy, sbe, mbe, mem_req, mem_we;
  logic [NB-1:0]  lock;
  logic [WAW-1:0] mem_addr;
  logic [EW-1:0]  mem_wdata, mem_rdata;

  always #2.5 clk = ~clk;

  scrub_engine #(.NB(NB), .BANK_AW(BANK_AW)) i_scrub_engine (
    .clk_i(clk), .rst_ni(rst_n), .rfa_we_i(rfa_we), .rfa_wdata_i(rfa_wdata),
    .ecc_dis_i(ecc_dis), .flag_clr_i(flag_clr), .rfa_o(rfa), .busy_o(busy),
    .sbe_flag_o(sbe), .mbe_flag_o(mbe), .bank_lock_o(lock), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  logic [EW-1:0] mem [0:(1<<WAW)-1];
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0, fails = 0;
  bit exp_sbe = 0, exp_mbe = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // independent model of the stored codeword layout
  function automatic logic [EW-1:0] b_enc(input logic [31:0] d);
    logic [38:1] h;
    logic [5:0]  c;
    int j;
    h = '0; c = '0; j = 0;
    for (int p = 1; p <= 38; p++) if ((p & (p - 1)) != 0) begin h[p] = d[j]; j++; end
    for (int k = 0; k < 6; k++)
      for (int p = 1; p <= 38; p++) if (p[k]) c[k] = c[k] ^ h[p];
    return {^{c, d}, c, d};
  endfunction

  typedef struct packed { logic [WAW-1:0] a; logic [EW-1:0] d; } wr_item_t;
  wr_item_t exp_q[$];
  wr_item_t mon_it;

  // monitor: every SRAM write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_we) begin
      if (exp_q.size() == 0) chk(0, "R5", "unexpected write", 64'(mem_addr), 64'h0);
      else begin
        mon_it = exp_q.pop_front();
        chk(mem_addr == mon_it.a && mem_wdata == mon_it.d, "R4", "write-back",
            {15'h0, mem_addr, 1'b0, mem_wdata}, {15'h0, mon_it.a, 1'b0, mon_it.d});
      end
    end
  end

  // driver side: seed a word with a fault pattern and predict its write-back
  task automatic seed(input logic [WAW-1:0] w, input logic [31:0] d, input logic [EW-1:0] flip,
                      input bit push);
    mem[w] = b_enc(d) ^ flip;
    if ($countones(flip) == 1) exp_sbe = 1;
    if ($countones(flip) == 2) exp_mbe = 1;
    if (push && $countones(flip) < 2) exp_q.push_back('{a: w, d: b_enc(d)});
  endtask

  task automatic scrub(input logic [AW-1:0] a, input bit run, input bit intrude, input string tag);
    logic [AW-1:0]  al;
    logic [NB-1:0]  explock;
    logic [WAW-1:0] rd0, rd1;
    int nbusy, nrd;
    al = {a[AW-1:3], 3'b000};
    explock = NB'(1) << al[AW-1:BANK_AW];
    nbusy = 0; nrd = 0; rd0 = '0; rd1 = '0;
    @(negedge clk); rfa_we = 1; rfa_wdata = a;
    @(negedge clk); rfa_we = 0;
    chk(rfa == al, "R2", "aligned address", 64'(rfa), 64'(al));
    for (int i = 0; i < 8; i++) begin
      if (busy) begin
        nbusy++;
        chk(lock == explock, "R7", "lock while busy", 64'(lock), 64'(explock));
      end else chk(lock == '0, "R7", "lock while idle", 64'(lock), 64'h0);
      if (mem_req && !mem_we) begin
        if (nrd == 0) rd0 = mem_addr; else rd1 = mem_addr;
        nrd++;
      end
      if (intrude && i == 1) begin rfa_we = 1; rfa_wdata = a ^ AW'(11'h408); end
      else rfa_we = 0;
      @(negedge clk);
    end
    chk(nbusy == (run ? 4 : 0), "R6", {tag, " busy cycles"}, 64'(nbusy), run ? 64'd4 : 64'd0);
    chk(nrd == (run ? 2 : 0), "R3", {tag, " read count"}, 64'(nrd), run ? 64'd2 : 64'd0);
    if (run) begin
      chk(rd0 == al[AW-1:2] && rd1 == al[AW-1:2] + 1, "R3", "read order",
          {rd0, 32'h0, rd1}, {al[AW-1:2], 32'h0, al[AW-1:2] + WAW'(1)});
      chk(exp_q.size() == 0, "R4", {tag, " pending writes"}, 64'(exp_q.size()), 64'h0);
    end
    if (intrude) chk(rfa == al, "R8", "address held while busy", 64'(rfa), 64'(al));
    chk(sbe == exp_sbe, "R4", {tag, " sbe flag"}, 64'(sbe), 64'(exp_sbe));
    chk(mbe == exp_mbe, "R5", {tag, " mbe flag"}, 64'(mbe), 64'(exp_mbe));
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [WAW-1:0] w;
    for (int i = 0; i < (1 << WAW); i++) mem[i] = b_enc(32'h0);
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !sbe && !mbe && lock == '0 && !mem_req && rfa == '0, "R1", "reset state",
        {busy, sbe, mbe, lock, mem_req, rfa}, 64'h0);

    // clean pair
    seed(9'h002, 32'hDEAD_BEEF, '0, 1); seed(9'h003, 32'h1234_5678, '0, 1);
    scrub(11'h008, 1, 0, "clean");

    // data bit in word 0, check bit in word 1
    seed(9'h010, 32'hA5A5_0F0F, EW'(1) << 17, 1); seed(9'h011, 32'h0BAD_F00D, EW'(1) << 34, 1);
    scrub(11'h043, 1, 0, "single");

    chk(sbe && !mbe, "R10", "sbe set only", {sbe, mbe}, 2'b10);
    @(negedge clk); flag_clr = 2'b01;
    @(negedge clk); flag_clr = 2'b00; exp_sbe = 0;
    chk(!sbe, "R10", "sbe cleared", 64'(sbe), 64'h0);

    // overall parity bit fault in word 0, double fault in word 1
    seed(9'h0A0, 32'h7777_1111, EW'(1) << 38, 1);
    seed(9'h0A1, 32'hCAFE_0001, (EW'(1) << 3) | (EW'(1) << 20), 1);
    scrub(11'h284, 1, 0, "parity+double");
    chk(mem[9'h0A1] == (b_enc(32'hCAFE_0001) ^ ((EW'(1) << 3) | (EW'(1) << 20))), "R5",
        "uncorrectable word left in place", 64'(mem[9'h0A1]), 64'h0);

    @(negedge clk); flag_clr = 2'b10;
    @(negedge clk); flag_clr = 2'b00; exp_mbe = 0;
    chk(!mbe && sbe, "R10", "mbe cleared, sbe kept", {sbe, mbe}, 2'b10);
    @(negedge clk); flag_clr = 2'b01;
    @(negedge clk); flag_clr = 2'b00; exp_sbe = 0;

    // double fault in word 0, good word 1
    seed(9'h0C0, 32'h5555_AAAA, (EW'(1) << 0) | (EW'(1) << 33), 1);
    seed(9'h0C1, 32'h0F0F_F0F0, '0, 1);
    scrub(11'h300, 1, 0, "double word0");

    // address write while busy is ignored
    seed(9'h040, 32'h1111_2222, '0, 1); seed(9'h041, 32'h3333_4444, EW'(1) << 5, 1);
    scrub(11'h100, 1, 1, "intrude");

    // disabled bank: no access, no busy, address still updated
    ecc_dis = 8'b0000_0100;
    w = 9'h080;
    seed(w, 32'h9999_0000, EW'(1) << 7, 0);
    exp_sbe = sbe;
    scrub(11'h200, 0, 0, "R9 disabled");
    chk(mem[w] == (b_enc(32'h9999_0000) ^ (EW'(1) << 7)), "R9", "disabled bank untouched",
        64'(mem[w]), 64'(b_enc(32'h9999_0000) ^ (EW'(1) << 7)));
    ecc_dis = '0;

    // sweep across the bank 0 / bank 1 boundary
    for (int s = 0; s < 4; s++) begin
      logic [AW-1:0] ba;
      ba = 11'h0F0 + AW'(8 * s);
      seed(ba[AW-1:2], 32'h4000_0000 + 32'(s), EW'(1) << (s + 1), 1);
      seed(ba[AW-1:2] + 1, 32'h8000_0000 + 32'(s), '0, 1);
      scrub(ba, 1, 0, "R11 sweep");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule